// File: doc/BRIEF.md
# Dual-Sample Board Energy Summer

This block forms the energy sum of one digitizer board on every logic clock. The converters behind it sample at twice the logic rate, so each channel hands over two 8-bit samples per clock: an earlier one (phase A) and a later one (phase B). Two matched pipelined adder trees run side by side, one per phase. Every clock they produce two board sums, each 12 bits wide.

A per-beat mode input selects reduced-precision operation. In that mode the two phase sums of a beat are averaged into a single 12-bit value. This gives up the half-clock time resolution and halves the output bandwidth. The mode bit moves through the pipeline alongside its data, so the mode can change on any beat.

A channel enable mask removes individual channels from both sums. An input strobe marks which beats carry samples. The number of channels must be a power of two, and the pipeline depth is the base-2 logarithm of the channel count.

Top module: `board_energy_sum`

## Requirements
- R1: In full mode (`avg_mode_i`=0), `sum_a_o` and `sum_b_o` equal the sums of the enabled channels' phase-A and phase-B samples of one beat. Channel i occupies bits [8i+7:8i] of `samp_a_i` and of `samp_b_i`.
- R2: `valid_o` equals `valid_i` delayed by exactly 4 clocks (16 channels).
- R3: With all 16 channels at 255 the sums are 4080 and do not wrap.
- R4: In averaging mode (`avg_mode_i`=1), `sum_a_o` is floor((A+B)/2), where A and B are the two phase sums, and `sum_b_o` is 0. The latency is the same 4 clocks.
- R5: `avg_o` equals `avg_mode_i` delayed by 4 clocks. Consecutive beats in alternating modes each come out in their own mode.
- R6: A 0 in bit i of `chan_en_i` removes channel i from both phase sums of that beat.
- R7: Any output beat whose `valid_o` is 0 has both sums equal to 0.
- R8: During and right after reset, `valid_o`, `avg_o`, `sum_a_o` and `sum_b_o` are all 0.
- R9: A new beat is accepted on every clock, and back-to-back beats produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_a_i | input | 128 | Earlier sample of each channel, 8 bits per channel |
| samp_b_i | input | 128 | Later sample of each channel, 8 bits per channel |
| chan_en_i | input | 16 | Per-channel enable, bit i for channel i |
| valid_i | input | 1 | Beat carries samples |
| avg_mode_i | input | 1 | 1 selects pair averaging for this beat |
| sum_a_o | output | 12 | Phase-A sum, or the average in averaging mode |
| sum_b_o | output | 12 | Phase-B sum, 0 in averaging mode |
| valid_o | output | 1 | Output beat valid |
| avg_o | output | 1 | Output beat was taken in averaging mode |

## Verification
The bench builds the block with its defaults: 16 channels of 8 bits, four tree levels and 12-bit sums. At that size a saturated board gives exactly 4080, so the edge of the output range is tested directly. A walking channel mask covers each leaf of both trees. Beats are issued every clock with mixed modes and strobe gaps, so each stage of the pipeline holds a different beat at the same time. Odd phase totals check the truncation of the average.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic {MODE_FULL = 1'b0, MODE_AVG = 1'b1} sum_mode_e;

  // Mean of two phase sums, rounded down; callers zero-extend into 32 bits.
  function automatic logic [31:0] pair_avg(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] tot;
    tot = {1'b0, a} + {1'b0, b};
    return tot[32:1];
  endfunction
endpackage

// File: rtl/lane_mask.sv
module lane_mask #(
  parameter int NCH = 16,
  parameter int SW  = 8
) (
  input  logic [NCH*SW-1:0] lanes_i,
  input  logic [NCH-1:0]    en_i,
  input  logic              live_i,
  output logic [NCH*SW-1:0] lanes_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign lanes_o[c*SW +: SW] = (en_i[c] && live_i) ? lanes_i[c*SW +: SW] : '0;
  end
endmodule

// File: rtl/adder_tree.sv
module adder_tree #(
  parameter int NCH = 16,
  parameter int SW  = 8,
  localparam int LVL = $clog2(NCH),
  localparam int OW  = SW + LVL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] lanes_i,
  output logic [OW-1:0]     sum_o
);
  localparam int unsigned PEAK = NCH * ((1 << SW) - 1);

  for (genvar lv = 0; lv <= LVL; lv++) begin : g_lv
    localparam int N = NCH >> lv;
    logic [OW-1:0] node [N];
    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_in
        assign node[i] = OW'(lanes_i[i*SW +: SW]);
      end
    end else begin : g_add
      for (genvar i = 0; i < N; i++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) node[i] <= '0;
          else        node[i] <= g_lv[lv-1].node[2*i] + g_lv[lv-1].node[2*i+1];
        end
      end
    end
  end

  assign sum_o = g_lv[LVL].node[0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sum_o) <= PEAK)
    else $error("tree root exceeds board peak");
endmodule

// File: rtl/delay_line.sv
module delay_line #(
  parameter int W     = 2,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];
  logic [CW-1:0] warm_cnt;
  logic warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
      warm_cnt <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
      if (!warm) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign warm = (warm_cnt == CW'(DEPTH));
  assign dout = stage[DEPTH-1];

  // bit 0 carries the strobe, bit W-1 the mode
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> dout[0] == $past(din[0], DEPTH))
    else $error("strobe delay mismatch");
  assert_mode_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> dout[W-1] == $past(din[W-1], DEPTH))
    else $error("mode delay mismatch");
endmodule

// File: rtl/board_energy_sum.sv
module board_energy_sum #(
  parameter int NCH = 16,
  parameter int SW  = 8,
  localparam int LAT = $clog2(NCH),
  localparam int OW  = SW + LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] samp_a_i,
  input  logic [NCH*SW-1:0] samp_b_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic              valid_i,
  input  logic              avg_mode_i,
  output logic [OW-1:0]     sum_a_o,
  output logic [OW-1:0]     sum_b_o,
  output logic              valid_o,
  output logic              avg_o
);
  import bes_pkg::*;

  logic [NCH*SW-1:0] gated_a, gated_b;
  logic [OW-1:0]     tree_a, tree_b;
  logic [1:0]        side_out;
  sum_mode_e         out_mode;
  logic [31:0]       avg_full;

  lane_mask #(.NCH(NCH), .SW(SW)) u_mask_a (
    .lanes_i(samp_a_i), .en_i(chan_en_i), .live_i(valid_i), .lanes_o(gated_a));
  lane_mask #(.NCH(NCH), .SW(SW)) u_mask_b (
    .lanes_i(samp_b_i), .en_i(chan_en_i), .live_i(valid_i), .lanes_o(gated_b));

  adder_tree #(.NCH(NCH), .SW(SW)) u_tree_a (
    .clk(clk), .rst_n(rst_n), .lanes_i(gated_a), .sum_o(tree_a));
  adder_tree #(.NCH(NCH), .SW(SW)) u_tree_b (
    .clk(clk), .rst_n(rst_n), .lanes_i(gated_b), .sum_o(tree_b));

  delay_line #(.W(2), .DEPTH(LAT)) u_side (
    .clk(clk), .rst_n(rst_n), .din({avg_mode_i, valid_i}), .dout(side_out));

  assign out_mode = sum_mode_e'(side_out[1]);
  assign avg_full = pair_avg(32'(tree_a), 32'(tree_b));
  assign valid_o  = side_out[0];
  assign avg_o    = (out_mode == MODE_AVG);
  assign sum_a_o  = avg_o ? avg_full[OW-1:0] : tree_a;
  assign sum_b_o  = avg_o ? '0 : tree_b;

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (sum_a_o == '0 && sum_b_o == '0))
    else $error("sum present on an idle beat");
  assert_avg_b_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    avg_o |-> sum_b_o == '0)
    else $error("phase-B sum present in averaging mode");
endmodule

// File: tb/board_energy_sum_tb.sv
module board_energy_sum_tb;
  localparam int NCH = 16;
  localparam int SW  = 8;
  localparam int OW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*SW-1:0] samp_a = '0, samp_b = '0;
  logic [NCH-1:0] chan_en = '0;
  logic valid = 1'b0, avg_mode = 1'b0;
  logic [OW-1:0] sum_a, sum_b;
  logic valid_q, avg_q;

  int vectors = 0, miscompares = 0, beat_no = 0, cycles = 0;

  logic [OW-1:0] h_a [4];
  logic [OW-1:0] h_b [4];
  logic          h_v [4];
  logic          h_m [4];
  string         h_tag [4];

  board_energy_sum #(.NCH(NCH), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_a_i(samp_a), .samp_b_i(samp_b),
    .chan_en_i(chan_en), .valid_i(valid), .avg_mode_i(avg_mode),
    .sum_a_o(sum_a), .sum_b_o(sum_b), .valid_o(valid_q), .avg_o(avg_q));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic int phase_sum(logic [NCH*SW-1:0] v, logic [NCH-1:0] en, logic live);
    int s = 0;
    for (int c = 0; c < NCH; c++) if (en[c] && live) s += int'(v[c*SW +: SW]);
    return s;
  endfunction

  task automatic check_slot(int slot);
    vectors++;
    if (sum_a !== h_a[slot] || sum_b !== h_b[slot] || valid_q !== h_v[slot] || avg_q !== h_m[slot]) begin
      miscompares++;
      $display("FAIL %s beat %0d: actual a=%0d b=%0d v=%0b m=%0b expected a=%0d b=%0d v=%0b m=%0b",
               h_tag[slot], beat_no, sum_a, sum_b, valid_q, avg_q,
               h_a[slot], h_b[slot], h_v[slot], h_m[slot]);
    end
  endtask

  // Called at a falling edge: checks the beat issued 4 clocks earlier, then drives the next one.
  task automatic drive_beat(logic [NCH*SW-1:0] a, logic [NCH*SW-1:0] b,
                            logic [NCH-1:0] en, logic v, logic m, string tag);
    int slot = beat_no % 4;
    int sa = phase_sum(a, en, v);
    int sb = phase_sum(b, en, v);
    check_slot(slot);
    samp_a = a; samp_b = b; chan_en = en; valid = v; avg_mode = m;
    h_v[slot] = v; h_m[slot] = m; h_tag[slot] = tag;
    if (m) begin h_a[slot] = OW'((sa + sb) / 2); h_b[slot] = '0; end
    else   begin h_a[slot] = OW'(sa);            h_b[slot] = OW'(sb); end
    beat_no++;
    @(negedge clk);
  endtask

  task automatic t_reset();  // R8
    for (int s = 0; s < 4; s++) begin
      h_a[s] = '0; h_b[s] = '0; h_v[s] = 1'b0; h_m[s] = 1'b0; h_tag[s] = "R8";
    end
    repeat (3) @(negedge clk);
    vectors++;
    if (sum_a !== '0 || sum_b !== '0 || valid_q !== 1'b0 || avg_q !== 1'b0) begin
      miscompares++;
      $display("FAIL R8 in reset: actual a=%0d b=%0d v=%0b m=%0b expected all 0", sum_a, sum_b, valid_q, avg_q);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) drive_beat('0, '0, '1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_full_patterns();  // R1, R9: random and ramp beats, back to back
    logic [NCH*SW-1:0] a, b;
    for (int k = 0; k < 12; k++) begin
      for (int c = 0; c < NCH; c++) begin
        a[c*SW +: SW] = (k < 2) ? SW'(c * 16 + k) : SW'($urandom);
        b[c*SW +: SW] = (k < 2) ? SW'(255 - c) : SW'($urandom);
      end
      drive_beat(a, b, '1, 1'b1, 1'b0, (k % 2) ? "R9" : "R1");
    end
  endtask

  task automatic t_overflow();  // R3
    drive_beat('1, '1, '1, 1'b1, 1'b0, "R3");
    drive_beat('1, '0, '1, 1'b1, 1'b0, "R3");
    drive_beat('1, '1, '1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_mask();  // R6: walking disable, then a single live channel
    logic [NCH*SW-1:0] a, b;
    for (int c = 0; c < NCH; c++) begin
      a[c*SW +: SW] = SW'(c + 1); b[c*SW +: SW] = SW'(100 + c);
    end
    for (int c = 0; c < NCH; c++) drive_beat(a, b, ~(NCH'(1) << c), 1'b1, 1'b0, "R6");
    drive_beat(a, b, NCH'(1) << 7, 1'b1, 1'b0, "R6");
    drive_beat('1, '1, '0, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_avg();  // R4: odd totals truncate downward
    logic [NCH*SW-1:0] a, b;
    a = '0; b = '0;
    a[7:0] = 8'd3; b[7:0] = 8'd0;
    drive_beat(a, b, '1, 1'b1, 1'b1, "R4");
    a[15:8] = 8'd200; b[23:16] = 8'd101;
    drive_beat(a, b, '1, 1'b1, 1'b1, "R4");
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < NCH; c++) begin
        a[c*SW +: SW] = SW'($urandom); b[c*SW +: SW] = SW'($urandom);
      end
      drive_beat(a, b, NCH'($urandom), 1'b1, 1'b1, "R4");
    end
  endtask

  task automatic t_mode_switch();  // R5
    logic [NCH*SW-1:0] a, b;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < NCH; c++) begin
        a[c*SW +: SW] = SW'($urandom); b[c*SW +: SW] = SW'($urandom);
      end
      drive_beat(a, b, '1, 1'b1, k[0], "R5");
    end
  endtask

  task automatic t_gaps();  // R2, R7: strobe gaps with live-looking data
    for (int k = 0; k < 10; k++)
      drive_beat('1, '1, '1, (k % 3) == 0, k[1], (k % 2) ? "R7" : "R2");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_patterns();
    t_overflow();
    t_mask();
    t_avg();
    t_mode_switch();
    t_gaps();
    for (int k = 0; k < 4; k++) drive_beat('0, '0, '0, 1'b0, 1'b0, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule